// File: doc/BRIEF.md
# Package Thermal Status Word with Sticky Event Logs

This block holds a 32-bit thermal status word for a processor package. Three thermal events feed it: activation of the thermal control circuit, assertion of the bidirectional processor-hot signal, and a critical-temperature condition. Each event has a live status bit, which follows the synchronized input, and a sticky log bit. The log bit latches the first rising edge of its status bit and stays set until the host clears it.

The host reads the word with a single read-and-clear command that carries a 32-bit active-low clear mask. The block returns the word as it stood at the moment the command was accepted. If every zero in the mask falls on a log position, the block clears the selected logs and returns completion code 0x40. If any zero falls on another position, the block rejects the whole command with code 0x90 and changes no log bit. A rising edge that lands in the same cycle as a clear of its own log keeps the log set, so no event is lost.

A two-state machine sequences commands. In `ST_IDLE` a command is accepted and the machine takes transition `ACCEPT` to `ST_RESP`. In `ST_RESP` the response is shown for one cycle, and transition `RETIRE` always returns the machine to `ST_IDLE`.

Top module: `thermal_status_word`

## Requirements
- R1: The word layout is: bit 0 control-circuit status, bit 1 control-circuit log, bit 2 processor-hot status, bit 3 processor-hot log, bit 4 critical status, bit 5 critical log. Bits 31..6 read 0. Event input `evt_in[0]` drives the control circuit, `evt_in[1]` drives processor-hot and `evt_in[2]` drives critical.
- R2: A log bit sets only on a 0-to-1 transition of its synchronized status bit. A status that stays high does not set the log again after the log is cleared.
- R3: A log bit stays set after its status bit returns to 0.
- R4: In an accepted command, a 0 at mask bit 1, 3 or 5 clears that log, and a 1 leaves it unchanged. For example, mask 0xFFFFFFFD clears only the control-circuit log.
- R5: A 0 at any mask position other than 1, 3 or 5 makes the command fail with code 0x90, and no log bit is cleared.
- R6: A command whose mask is legal completes with code 0x40.
- R7: The returned word is the value held before the mask is applied.
- R8: When a log's rising edge and a clear of that log fall in the same cycle, the log ends set.
- R9: Reset clears every log bit, the synchronizer and the edge history. A status input that is high when reset releases is therefore logged as a rising edge. During reset no response is valid.
- R10: Status inputs pass through two synchronizing flops, so a log bit shows three clock edges after its input rises. `rsp_valid` is high for exactly the one cycle after the edge that accepted the command. A command presented while a response is being shown is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_in | input | 3 | Asynchronous event status inputs (control circuit, processor-hot, critical) |
| cmd_valid | input | 1 | Read-and-clear command strobe |
| cmd_mask | input | 32 | Active-low clear mask carried by the command |
| rsp_valid | output | 1 | Response is valid this cycle |
| rsp_word | output | 32 | Status word as it stood before clearing |
| rsp_code | output | 8 | Completion code: 0x40 for success, 0x90 for an illegal mask |

## Verification
Two functions can fall in the same cycle: the edge detector setting a log, and a read command clearing that same log. The bench raises the critical event input and times a command with mask 0xFFFFFFDF so that the command is sampled on the exact edge where the synchronized rise is first seen. That response must show status set and log clear. A following all-ones read must show the log set, which confirms that the set won over the clear. A second overlap, a command arriving while a response is still being shown, is judged by the absence of a second response and by the log being left untouched.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_EVT     = 3;
    localparam int CODE_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam logic [CODE_W-1:0] CODE_OK  = 8'h40;
    localparam logic [CODE_W-1:0] CODE_BAD = 8'h90;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } tsw_state_e;

    // Mask positions a host may legally clear: the odd bit of each event pair.
    function automatic logic [WORD_W-1:0] log_positions(input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[2*i+1] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tsw_sync.sv
module tsw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tsw_log_bank.sv
module tsw_log_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat,
    input  logic [N-1:0] clr,
    output logic [N-1:0] log_q
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    assign rise = stat & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            log_q  <= '0;
        end else begin
            prev_q <= stat;
            log_q  <= (log_q & ~clr) | rise;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_LOG_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(log_q[i]) |-> $past(stat[i]) && !$past(prev_q[i])); // R2
        AST_LOG_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(log_q[i]) |-> $past(clr[i])); // R4
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !prev_q[i] && clr[i]) |=> log_q[i]); // R8
    end
endmodule

// File: rtl/tsw_cmd_fsm.sv
module tsw_cmd_fsm
    import tsw_pkg::*;
#(
    parameter int N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_mask,
    input  logic [N-1:0]      stat,
    input  logic [N-1:0]      logs,
    output logic [N-1:0]      clr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic [CODE_W-1:0] rsp_code
);
    localparam logic [WORD_W-1:0] LEGAL = log_positions(N);

    tsw_state_e state_q, state_d;
    logic [WORD_W-1:0] word_now;
    logic fire, legal;

    always_comb begin
        word_now = '0;
        for (int i = 0; i < N; i++) begin
            word_now[2*i]   = stat[i];
            word_now[2*i+1] = logs[i];
        end
    end

    assign fire  = cmd_valid && (state_q == ST_IDLE);
    assign legal = ((~cmd_mask) & ~LEGAL) == '0;

    always_comb begin
        for (int i = 0; i < N; i++) clr[i] = fire && legal && !cmd_mask[2*i+1];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fire) state_d = ST_RESP;  // ACCEPT
            ST_RESP: state_d = ST_IDLE;            // RETIRE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_word <= '0;
            rsp_code <= '0;
        end else if (fire) begin
            rsp_word <= word_now;
            rsp_code <= legal ? CODE_OK : CODE_BAD;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code == CODE_OK || rsp_code == CODE_BAD)); // R6
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_word[WORD_W-1:2*N] == '0)); // R1
    AST_BAD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && state_q == ST_IDLE && (cmd_mask | LEGAL) != '1) |=> $past(logs) == (logs & $past(logs))
            || ((logs & ~$past(logs)) != '0)); // R5
endmodule

// File: rtl/thermal_status_word.sv
module thermal_status_word
    import tsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_mask,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic [CODE_W-1:0] rsp_code
);
    logic [NUM_EVT-1:0] stat_s;
    logic [NUM_EVT-1:0] log_s;
    logic [NUM_EVT-1:0] clr_s;

    tsw_sync #(.W(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (evt_in),
        .q     (stat_s)
    );

    tsw_log_bank #(.N(NUM_EVT)) u_logs (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat_s),
        .clr   (clr_s),
        .log_q (log_s)
    );

    tsw_cmd_fsm #(.N(NUM_EVT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_mask  (cmd_mask),
        .stat      (stat_s),
        .logs      (log_s),
        .clr       (clr_s),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word),
        .rsp_code  (rsp_code)
    );
endmodule

// File: tb/thermal_status_word_tb_top.sv
module thermal_status_word_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  evt_in;
    logic        cmd_valid;
    logic [31:0] cmd_mask;
    logic        rsp_valid;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic [7:0]  code;
        string       req;
    } exp_t;
    exp_t sb_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_status_word dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .cmd_valid (cmd_valid),
        .cmd_mask  (cmd_mask),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word),
        .rsp_code  (rsp_code)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input logic [31:0] w, input logic [7:0] c, input string r);
        exp_t e;
        e.word = w; e.code = c; e.req = r;
        sb_q.push_back(e);
    endtask

    task automatic send_cmd(input logic [31:0] m, input logic [31:0] w,
                            input logic [7:0] c, input string r);
        cmd_valid = 1'b1;
        cmd_mask  = m;
        push_exp(w, c, r);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_mask  = '1;
        @(negedge clk);
    endtask

    task automatic check_bit(input logic act, input logic exp, input string r);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", r, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a response appears.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected response word %h expected none", rsp_word);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (rsp_word !== e.word) begin
                    errors++;
                    $display("FAIL %s word actual %h expected %h", e.req, rsp_word, e.word);
                end
                checks++;
                if (rsp_code !== e.code) begin
                    errors++;
                    $display("FAIL %s code actual %h expected %h", e.req, rsp_code, e.code);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; evt_in = '0; cmd_valid = 1'b0; cmd_mask = '1;
        idle(3);
        check_bit(rsp_valid, 1'b0, "R9 reset rsp_valid");
        rst_n = 1'b1;
        idle(2);

        send_cmd(32'hFFFF_FFFF, 32'h0, 8'h40, "R1 R6 empty word");

        evt_in[0] = 1'b1; idle(3);
        send_cmd(32'hFFFF_FFFF, 32'h3, 8'h40, "R1 R2 control log set");
        send_cmd(32'hFFFF_FFFD, 32'h3, 8'h40, "R7 R4 pre-clear word");
        send_cmd(32'hFFFF_FFFF, 32'h1, 8'h40, "R2 R4 no re-set on level");

        evt_in[0] = 1'b0; idle(3);
        evt_in[1] = 1'b1; idle(3);
        evt_in[1] = 1'b0; idle(3);
        send_cmd(32'hFFFF_FFFF, 32'h8, 8'h40, "R3 sticky after fall");

        send_cmd(32'hFFFF_FFF6, 32'h8, 8'h90, "R5 zero at status bit");
        send_cmd(32'h7FFF_FFFF, 32'h8, 8'h90, "R5 zero at bit 31");
        send_cmd(32'hFFFF_FFFF, 32'h8, 8'h40, "R5 log kept after reject");

        evt_in[2] = 1'b1; idle(3);
        send_cmd(32'hFFFF_FFD7, 32'h38, 8'h40, "R4 R7 clear two logs");
        send_cmd(32'hFFFF_FFFF, 32'h10, 8'h40, "R4 both cleared");

        // R8: command sampled on the edge where the synchronized rise is seen.
        evt_in[2] = 1'b0; idle(3);
        evt_in[2] = 1'b1; idle(2);
        send_cmd(32'hFFFF_FFDF, 32'h10, 8'h40, "R8 overlap snapshot");
        send_cmd(32'hFFFF_FFFF, 32'h30, 8'h40, "R8 set wins over clear");

        // R10: second command during the response cycle is ignored.
        cmd_valid = 1'b1; cmd_mask = 32'hFFFF_FFFF;
        push_exp(32'h30, 8'h40, "R10 first command");
        @(negedge clk);
        cmd_mask = 32'hFFFF_FFDF;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_mask = '1;
        check_bit(rsp_valid, 1'b0, "R10 single response pulse");
        @(negedge clk);
        send_cmd(32'hFFFF_FFFF, 32'h30, 8'h40, "R10 ignored command left log");

        // R9: reset clears logs; a high input at release counts as a rise.
        evt_in[1] = 1'b1; idle(3);
        evt_in[1] = 1'b0; idle(3);
        rst_n = 1'b0;
        idle(3);
        check_bit(rsp_valid, 1'b0, "R9 rsp_valid in reset");
        check_bit(rsp_word[3], 1'b0, "R9 word cleared in reset");
        rst_n = 1'b1;
        idle(3);
        send_cmd(32'hFFFF_FFFF, 32'h30, 8'h40, "R9 logs cleared, high input logged");

        idle(4);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R10 missing responses actual %0d expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule